// File: doc/BRIEF.md
# Sleep Mode and Clock Gating Controller

This controller sits beside a small processor core and decides which clock domains and oscillators keep running when the core goes to sleep. Software picks a sleep mode through a 3-bit select field, arms it with a sleep-enable bit, and then issues a sleep strobe. Two configuration inputs shape the decision. One says whether an external crystal or resonator is fitted. The other says whether the low-power timer runs from its own asynchronous oscillator.

While the core sleeps, the controller watches two kinds of wake source: timer events and external interrupt lines. Which of them it accepts depends on the mode. When a wake is accepted, the domain and oscillator enables are restored at once. The CPU clock stays off for a mode-dependent start-up latency, and a one-cycle done pulse marks the moment the CPU clock returns.

A per-peripheral power-reduction register gates each peripheral's clock. While a peripheral is gated, its state is frozen, reads from it return zero and writes to it are dropped. Clearing its bit resumes the peripheral from where it stopped.

Top module: `slp_pwr_ctrl`

## Requirements
- R1: The sleep strobe has no effect unless sleep_en is 1. The valid select codes are 000 Idle, 010 Power-down, 011 Power-save and 110 Standby. Code 110 with xtal_cfg=0, and any other code, leave the core awake with every enable at its awake value.
- R2: Idle turns off cpu_clk_en. io_clk_en, lpt_clk_en and main_osc_en stay 1, and lpt_osc_en equals lpt_async.
- R3: Power-down drives cpu_clk_en, io_clk_en, lpt_clk_en, main_osc_en and lpt_osc_en all to 0.
- R4: Power-save turns off the cpu and io domains. With lpt_async=1: lpt_osc_en=1, main_osc_en=0 and lpt_clk_en=0. With lpt_async=0: lpt_osc_en=0, main_osc_en=1 and lpt_clk_en=1.
- R5: Standby gives the same enables as Power-down, except that main_osc_en stays 1.
- R6: A lpt_evt wakes the core only in Idle or Power-save, and only when both lpt_ie and gie are 1.
- R7: An ext_req line wakes the core only when gie=1. In Idle any line wakes it. In the other modes a line wakes it only if its ext_level bit is 1 (level-triggered).
- R8: On the clock edge that accepts a wake, sleeping falls and the io, lpt and oscillator enables return to their awake values. cpu_clk_en then stays 0 for the mode's latency: 6 cycles in Standby, IDLE_WAKE_CYC (default 2) in Idle, DEEP_WAKE_CYC (default 16) in Power-down and Power-save. cpu_clk_en returns to 1 in the same cycle as a one-cycle wake_done pulse.
- R9: pr_clk_en[i] equals io_clk_en AND NOT bit i of the power-reduction register. So all bits are 0 in every sleep mode except Idle. The register is written with pr_wr/pr_wdata and resets to 0.
- R10: While bit i is set, a read with acc_idx=i returns 0 on acc_rdata and a write does not raise per_wr[i]. While bit i is clear, acc_rdata carries slice i of per_rdata and per_wr[i] follows acc_wr.
- R11: After reset the core is awake, every clock and oscillator enable is at its awake value, all pr_clk_en bits are 1 and wake_done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_sel | input | 3 | Sleep mode select code |
| sleep_en | input | 1 | Arms the sleep strobe |
| sleep_strobe | input | 1 | Sleep request pulse |
| xtal_cfg | input | 1 | External crystal/resonator is fitted |
| lpt_async | input | 1 | Low-power timer runs from its asynchronous oscillator |
| lpt_evt | input | 1 | Timer overflow or compare event |
| lpt_ie | input | 1 | Timer interrupt enable |
| gie | input | 1 | Global interrupt enable |
| ext_req | input | NEXT | External interrupt requests |
| ext_level | input | NEXT | Per line: 1 means level-triggered |
| pr_wr | input | 1 | Power-reduction register write strobe |
| pr_wdata | input | NPER | Power-reduction register write value |
| acc_idx | input | IW | Peripheral selected for register access |
| acc_rd | input | 1 | Peripheral register read |
| acc_wr | input | 1 | Peripheral register write |
| per_rdata | input | NPER*DW | Read data from all peripherals |
| cpu_clk_en | output | 1 | CPU clock domain enable |
| io_clk_en | output | 1 | Peripheral clock domain enable |
| lpt_clk_en | output | 1 | Synchronous clock to low-power timer |
| main_osc_en | output | 1 | Main oscillator enable |
| lpt_osc_en | output | 1 | Timer oscillator enable |
| sleeping | output | 1 | Core is in a sleep mode |
| wake_done | output | 1 | One-cycle pulse when the CPU clock returns |
| pr_clk_en | output | NPER | Per-peripheral clock enables |
| acc_rdata | output | DW | Gated read data |
| per_wr | output | NPER | Gated per-peripheral write strobes |

## Verification
The bench targets the wake latency edge. A counter that is off by one would bring cpu_clk_en back one cycle early or late, or would misplace wake_done relative to it. It also checks Standby when no crystal is fitted: a design that forgot the crystal condition would put the core to sleep with the main oscillator held. Edge-triggered external lines in Power-down must not wake the core, and a timer event in Power-down or with its enable clear must not either; a lax wake qualifier would restore clocks early. Finally, it reads and writes a gated peripheral: leaking data or write strobes would show up directly on acc_rdata and per_wr.

// File: rtl/slp_pwr_pkg.sv
// Shared types for the sleep and clock gating controller.
// Assumes: the sleep select codes listed below are fixed by software convention.
package slp_pwr_pkg;

    typedef enum logic [2:0] {
        SM_IDLE  = 3'b000,
        SM_PDOWN = 3'b010,
        SM_PSAVE = 3'b011,
        SM_STBY  = 3'b110
    } sleep_mode_e;

    typedef enum logic [1:0] {
        ST_AWAKE  = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_WAKING = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic cpu;
        logic io;
        logic lpt;
        logic main_osc;
        logic lpt_osc;
    } dom_en_t;

    localparam int STBY_WAKE_CYC = 6;

endpackage

// File: rtl/slp_mode_decode.sv
// Turns the raw select field into a validated sleep mode.
// Assumes: Standby is legal only when an external crystal is configured;
// any code without a mode gives valid = 0.
module slp_mode_decode
    import slp_pwr_pkg::*;
(
    input  logic [2:0]  sel,
    input  logic        xtal,
    output logic        valid,
    output sleep_mode_e mode
);

    // Map each select code onto a mode and say whether it may be entered.
    always_comb begin
        valid = 1'b0;
        mode  = SM_IDLE;
        case (sel)
            3'b000: begin valid = 1'b1; mode = SM_IDLE;  end
            3'b010: begin valid = 1'b1; mode = SM_PDOWN; end
            3'b011: begin valid = 1'b1; mode = SM_PSAVE; end
            3'b110: begin valid = xtal; mode = SM_STBY;  end
            default: begin valid = 1'b0; mode = SM_IDLE; end
        endcase
    end

endmodule

// File: rtl/slp_seq.sv
// Sleep sequencer: awake -> sleep -> waking -> awake.
// Holds the latched mode and the wake-latency counter, and emits wake_done.
// Assumes: every latency parameter is at least 1.
module slp_seq
    import slp_pwr_pkg::*;
#(
    parameter int IDLE_WAKE_CYC = 2,
    parameter int DEEP_WAKE_CYC = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sleep_strobe,
    input  logic        sleep_en,
    input  logic        dec_valid,
    input  sleep_mode_e dec_mode,
    input  logic        wake_req,
    output pwr_state_e  state,
    output sleep_mode_e mode_q,
    output logic        wake_done
);

    localparam int MAX_A   = (IDLE_WAKE_CYC > DEEP_WAKE_CYC) ? IDLE_WAKE_CYC : DEEP_WAKE_CYC;
    localparam int MAX_LAT = (MAX_A > STBY_WAKE_CYC) ? MAX_A : STBY_WAKE_CYC;
    localparam int CW      = $clog2(MAX_LAT + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lat_sel;

    initial begin
        if (IDLE_WAKE_CYC < 1 || DEEP_WAKE_CYC < 1)
            $error("wake latencies must be at least 1");
    end

    // Pick the wake latency that belongs to the latched mode.
    always_comb begin
        case (mode_q)
            SM_IDLE: lat_sel = CW'(IDLE_WAKE_CYC);
            SM_STBY: lat_sel = CW'(STBY_WAKE_CYC);
            default: lat_sel = CW'(DEEP_WAKE_CYC);
        endcase
    end

    // State register, mode latch, latency countdown and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_AWAKE;
            mode_q    <= SM_IDLE;
            cnt       <= '0;
            wake_done <= 1'b0;
        end else begin
            wake_done <= 1'b0;
            case (state)
                ST_AWAKE: begin
                    if (sleep_strobe && sleep_en && dec_valid) begin
                        state  <= ST_SLEEP;
                        mode_q <= dec_mode;
                    end
                end
                ST_SLEEP: begin
                    if (wake_req) begin
                        state <= ST_WAKING;
                        cnt   <= lat_sel - CW'(1);
                    end
                end
                ST_WAKING: begin
                    if (cnt == '0) begin
                        state     <= ST_AWAKE;
                        wake_done <= 1'b1;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                default: state <= ST_AWAKE;
            endcase
        end
    end

    // R1: without sleep_en the strobe never leads to sleep
    a_r1_strobe_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AWAKE && !sleep_en) |=> (state != ST_SLEEP));

    // R8: the countdown steps by one and keeps the controller waking
    a_r8_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKING && cnt != '0) |=> (state == ST_WAKING && cnt == $past(cnt) - CW'(1)));

    // R8: wake_done lasts a single cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |=> !wake_done);

endmodule

// File: rtl/slp_mode_policy.sv
// Per-mode policy: domain/oscillator enables and wake-source qualification.
// Assumes: ext_level marks lines configured as level-triggered; edge lines
// are honoured only in Idle.
module slp_mode_policy
    import slp_pwr_pkg::*;
#(
    parameter int NEXT = 2
) (
    input  pwr_state_e  state,
    input  sleep_mode_e mode_q,
    input  logic        lpt_async,
    input  logic        lpt_evt,
    input  logic        lpt_ie,
    input  logic        gie,
    input  logic [NEXT-1:0] ext_req,
    input  logic [NEXT-1:0] ext_level,
    output dom_en_t     en,
    output logic        wake_req
);

    logic            tmr_live;
    logic [NEXT-1:0] ext_ok;

    // Decide enables and which wake sources count in the current state.
    always_comb begin
        en.cpu      = 1'b1;
        en.io       = 1'b1;
        en.lpt      = 1'b1;
        en.main_osc = 1'b1;
        en.lpt_osc  = lpt_async;
        tmr_live    = 1'b0;
        ext_ok      = '0;
        if (state == ST_SLEEP) begin
            case (mode_q)
                SM_IDLE: begin
                    en.cpu   = 1'b0;
                    tmr_live = 1'b1;
                    ext_ok   = ext_req;
                end
                SM_PSAVE: begin
                    en.cpu      = 1'b0;
                    en.io       = 1'b0;
                    en.lpt      = !lpt_async;
                    en.main_osc = !lpt_async;
                    en.lpt_osc  = lpt_async;
                    tmr_live    = 1'b1;
                    ext_ok      = ext_req & ext_level;
                end
                SM_STBY: begin
                    en.cpu      = 1'b0;
                    en.io       = 1'b0;
                    en.lpt      = 1'b0;
                    en.main_osc = 1'b1;
                    en.lpt_osc  = 1'b0;
                    ext_ok      = ext_req & ext_level;
                end
                default: begin
                    en.cpu      = 1'b0;
                    en.io       = 1'b0;
                    en.lpt      = 1'b0;
                    en.main_osc = 1'b0;
                    en.lpt_osc  = 1'b0;
                    ext_ok      = ext_req & ext_level;
                end
            endcase
        end
        wake_req = gie && ((tmr_live && lpt_evt && lpt_ie) || (|ext_ok));
    end

endmodule

// File: rtl/slp_prr.sv
// Power-reduction register with per-peripheral clock gating and access blocking.
// Assumes: a gated peripheral holds its state because its clock stops; this
// block only withholds the clock, read data and write strobes.
module slp_prr #(
    parameter int NPER = 8,
    parameter int DW   = 8,
    localparam int IW  = (NPER > 1) ? $clog2(NPER) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pr_wr,
    input  logic [NPER-1:0] pr_wdata,
    input  logic            io_clk_en,
    input  logic [IW-1:0]   acc_idx,
    input  logic            acc_rd,
    input  logic            acc_wr,
    input  logic [NPER*DW-1:0] per_rdata,
    output logic [NPER-1:0] pr_clk_en,
    output logic [DW-1:0]   acc_rdata,
    output logic [NPER-1:0] per_wr
);

    logic [NPER-1:0] pr_q;
    logic [DW-1:0]   rd_sel [NPER];

    // Power-reduction register, cleared at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pr_q <= '0;
        else if (pr_wr) pr_q <= pr_wdata;
    end

    // One gate per peripheral: clock enable, write strobe, read slice.
    for (genvar g = 0; g < NPER; g++) begin : g_per
        assign pr_clk_en[g] = io_clk_en & ~pr_q[g];
        assign per_wr[g]    = acc_wr && (acc_idx == IW'(g)) && !pr_q[g];
        assign rd_sel[g]    = pr_q[g] ? '0 : per_rdata[g*DW +: DW];
    end

    // Return the selected peripheral's (possibly blanked) read data.
    always_comb begin
        acc_rdata = '0;
        if (acc_rd && (int'(acc_idx) < NPER)) acc_rdata = rd_sel[acc_idx];
    end

    // R10: a gated peripheral never sees a write strobe
    a_r10_no_gated_write: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(acc_idx) < NPER && pr_q[acc_idx]) |-> !per_wr[acc_idx]);

endmodule

// File: rtl/slp_pwr_ctrl.sv
// Top of the sleep and clock gating controller. Wires decode, sequencer,
// mode policy and power-reduction gating together.
// Assumes: all inputs are synchronous to clk.
module slp_pwr_ctrl
    import slp_pwr_pkg::*;
#(
    parameter int NEXT          = 2,
    parameter int NPER          = 8,
    parameter int DW            = 8,
    parameter int IDLE_WAKE_CYC = 2,
    parameter int DEEP_WAKE_CYC = 16,
    localparam int IW           = (NPER > 1) ? $clog2(NPER) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         sleep_sel,
    input  logic               sleep_en,
    input  logic               sleep_strobe,
    input  logic               xtal_cfg,
    input  logic               lpt_async,
    input  logic               lpt_evt,
    input  logic               lpt_ie,
    input  logic               gie,
    input  logic [NEXT-1:0]    ext_req,
    input  logic [NEXT-1:0]    ext_level,
    input  logic               pr_wr,
    input  logic [NPER-1:0]    pr_wdata,
    input  logic [IW-1:0]      acc_idx,
    input  logic               acc_rd,
    input  logic               acc_wr,
    input  logic [NPER*DW-1:0] per_rdata,
    output logic               cpu_clk_en,
    output logic               io_clk_en,
    output logic               lpt_clk_en,
    output logic               main_osc_en,
    output logic               lpt_osc_en,
    output logic               sleeping,
    output logic               wake_done,
    output logic [NPER-1:0]    pr_clk_en,
    output logic [DW-1:0]      acc_rdata,
    output logic [NPER-1:0]    per_wr
);

    logic        dec_valid;
    sleep_mode_e dec_mode;
    sleep_mode_e mode_q;
    pwr_state_e  state;
    dom_en_t     en;
    logic        wake_req;

    slp_mode_decode u_dec (
        .sel   (sleep_sel),
        .xtal  (xtal_cfg),
        .valid (dec_valid),
        .mode  (dec_mode)
    );

    slp_seq #(
        .IDLE_WAKE_CYC (IDLE_WAKE_CYC),
        .DEEP_WAKE_CYC (DEEP_WAKE_CYC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_strobe (sleep_strobe),
        .sleep_en     (sleep_en),
        .dec_valid    (dec_valid),
        .dec_mode     (dec_mode),
        .wake_req     (wake_req),
        .state        (state),
        .mode_q       (mode_q),
        .wake_done    (wake_done)
    );

    slp_mode_policy #(.NEXT(NEXT)) u_pol (
        .state     (state),
        .mode_q    (mode_q),
        .lpt_async (lpt_async),
        .lpt_evt   (lpt_evt),
        .lpt_ie    (lpt_ie),
        .gie       (gie),
        .ext_req   (ext_req),
        .ext_level (ext_level),
        .en        (en),
        .wake_req  (wake_req)
    );

    // CPU clock also waits out the wake latency; other enables come from policy.
    assign cpu_clk_en  = en.cpu && (state == ST_AWAKE);
    assign io_clk_en   = en.io;
    assign lpt_clk_en  = en.lpt;
    assign main_osc_en = en.main_osc;
    assign lpt_osc_en  = en.lpt_osc;
    assign sleeping    = (state == ST_SLEEP);

    slp_prr #(.NPER(NPER), .DW(DW)) u_prr (
        .clk       (clk),
        .rst_n     (rst_n),
        .pr_wr     (pr_wr),
        .pr_wdata  (pr_wdata),
        .io_clk_en (io_clk_en),
        .acc_idx   (acc_idx),
        .acc_rd    (acc_rd),
        .acc_wr    (acc_wr),
        .per_rdata (per_rdata),
        .pr_clk_en (pr_clk_en),
        .acc_rdata (acc_rdata),
        .per_wr    (per_wr)
    );

    // R8: the CPU clock is off whenever the controller is not fully awake
    a_r8_cpu_off_until_awake: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_AWAKE) |-> !cpu_clk_en);

    // R9: no peripheral clock runs while the io domain is stopped
    a_r9_pr_follows_io: assert property (@(posedge clk) disable iff (!rst_n)
        !io_clk_en |-> (pr_clk_en == '0));

    // R5: Standby keeps the main oscillator but stops the io domain
    a_r5_standby_osc: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && mode_q == SM_STBY) |-> (main_osc_en && !io_clk_en && !lpt_osc_en));

    // R3: Power-down leaves every oscillator off
    a_r3_pdown_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && mode_q == SM_PDOWN) |-> (!main_osc_en && !lpt_osc_en && !lpt_clk_en));

endmodule

// File: tb/slp_pwr_ctrl_tb.sv
`timescale 1ns/1ps
// Directed bench for slp_pwr_ctrl: one task per scenario.
module slp_pwr_ctrl_tb_top;

    localparam int NEXT = 2;
    localparam int NPER = 8;
    localparam int DW   = 8;
    localparam int IW   = 3;
    localparam int IDLE_LAT = 2;
    localparam int DEEP_LAT = 16;
    localparam int STBY_LAT = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] sleep_sel = 3'b000;
    logic sleep_en = 1'b0, sleep_strobe = 1'b0, xtal_cfg = 1'b1, lpt_async = 1'b0;
    logic lpt_evt = 1'b0, lpt_ie = 1'b0, gie = 1'b1;
    logic [NEXT-1:0] ext_req = '0, ext_level = '0;
    logic pr_wr = 1'b0;
    logic [NPER-1:0] pr_wdata = '0;
    logic [IW-1:0] acc_idx = '0;
    logic acc_rd = 1'b0, acc_wr = 1'b0;
    logic [NPER*DW-1:0] per_rdata;
    logic cpu_clk_en, io_clk_en, lpt_clk_en, main_osc_en, lpt_osc_en, sleeping, wake_done;
    logic [NPER-1:0] pr_clk_en, per_wr;
    logic [DW-1:0] acc_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    slp_pwr_ctrl #(.NEXT(NEXT), .NPER(NPER), .DW(DW),
                   .IDLE_WAKE_CYC(IDLE_LAT), .DEEP_WAKE_CYC(DEEP_LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_sel(sleep_sel), .sleep_en(sleep_en),
        .sleep_strobe(sleep_strobe), .xtal_cfg(xtal_cfg), .lpt_async(lpt_async),
        .lpt_evt(lpt_evt), .lpt_ie(lpt_ie), .gie(gie), .ext_req(ext_req),
        .ext_level(ext_level), .pr_wr(pr_wr), .pr_wdata(pr_wdata), .acc_idx(acc_idx),
        .acc_rd(acc_rd), .acc_wr(acc_wr), .per_rdata(per_rdata),
        .cpu_clk_en(cpu_clk_en), .io_clk_en(io_clk_en), .lpt_clk_en(lpt_clk_en),
        .main_osc_en(main_osc_en), .lpt_osc_en(lpt_osc_en), .sleeping(sleeping),
        .wake_done(wake_done), .pr_clk_en(pr_clk_en), .acc_rdata(acc_rdata), .per_wr(per_wr)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare all five enables as {cpu,io,lpt,main_osc,lpt_osc}.
    task automatic chk_en(input string req, input logic [4:0] exp);
        chk(req, "enables", {27'd0, cpu_clk_en, io_clk_en, lpt_clk_en, main_osc_en, lpt_osc_en}, {27'd0, exp});
    endtask

    task automatic do_strobe(input logic [2:0] sel, input logic en);
        @(negedge clk);
        sleep_sel = sel; sleep_en = en; sleep_strobe = 1'b1;
        @(negedge clk);
        sleep_strobe = 1'b0; sleep_en = 1'b0;
    endtask

    // Caller has raised a wake source at a negedge; measure latency and done pulse.
    task automatic wake_measure(input string req, input int lat, input logic [4:0] awake_en);
        @(negedge clk);
        lpt_evt = 1'b0; ext_req = '0;
        chk(req, "sleeping after wake", {31'd0, sleeping}, 32'd0);
        chk(req, "io restored", {31'd0, io_clk_en}, 32'd1);
        for (int i = 0; i < lat; i++) begin
            if (i > 0) @(negedge clk);
            chk(req, "cpu held during latency", {31'd0, cpu_clk_en}, 32'd0);
        end
        @(negedge clk);
        chk(req, "cpu back", {31'd0, cpu_clk_en}, 32'd1);
        chk(req, "wake_done pulse", {31'd0, wake_done}, 32'd1);
        chk_en(req, awake_en);
        @(negedge clk);
        chk(req, "wake_done single", {31'd0, wake_done}, 32'd0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_en("R11", 5'b11110);
        chk("R11", "pr_clk_en", {24'd0, pr_clk_en}, 32'hFF);
        chk("R11", "wake_done", {31'd0, wake_done}, 32'd0);
        chk("R11", "sleeping", {31'd0, sleeping}, 32'd0);
    endtask

    task automatic t_gating;
        do_strobe(3'b010, 1'b0);
        chk("R1", "no sleep without en", {31'd0, sleeping}, 32'd0);
        chk_en("R1", 5'b11110);
        do_strobe(3'b101, 1'b1);
        chk("R1", "unassigned code", {31'd0, sleeping}, 32'd0);
        xtal_cfg = 1'b0;
        do_strobe(3'b110, 1'b1);
        chk("R1", "standby without crystal", {31'd0, sleeping}, 32'd0);
        chk_en("R1", 5'b11110);
        xtal_cfg = 1'b1;
    endtask

    task automatic t_idle;
        lpt_async = 1'b1;
        do_strobe(3'b000, 1'b1);
        chk_en("R2", 5'b01111);
        chk("R9", "idle pr clocks", {24'd0, pr_clk_en}, 32'hFF);
        @(negedge clk);
        lpt_evt = 1'b1; lpt_ie = 1'b0;
        @(negedge clk);
        lpt_evt = 1'b0;
        chk("R6", "no wake with ie clear", {31'd0, sleeping}, 32'd1);
        lpt_ie = 1'b1; lpt_evt = 1'b1;
        wake_measure("R8 idle", IDLE_LAT, 5'b11111);
        lpt_async = 1'b0;
        // R7: an edge line wakes Idle
        do_strobe(3'b000, 1'b1);
        @(negedge clk);
        ext_req = 2'b01; ext_level = 2'b00;
        wake_measure("R7 idle edge", IDLE_LAT, 5'b11110);
        lpt_ie = 1'b0;
    endtask

    task automatic t_pdown;
        do_strobe(3'b010, 1'b1);
        chk_en("R3", 5'b00000);
        chk("R9", "pdown pr clocks", {24'd0, pr_clk_en}, 32'h00);
        @(negedge clk);
        lpt_ie = 1'b1; lpt_evt = 1'b1; ext_req = 2'b10; ext_level = 2'b01;
        @(negedge clk);
        lpt_evt = 1'b0; ext_req = '0;
        chk("R6", "timer ignored in pdown", {31'd0, sleeping}, 32'd1);
        chk("R7", "edge line ignored in pdown", {31'd0, sleeping}, 32'd1);
        gie = 1'b0; ext_req = 2'b01;
        @(negedge clk);
        ext_req = '0;
        chk("R7", "level line needs gie", {31'd0, sleeping}, 32'd1);
        gie = 1'b1; ext_req = 2'b01;
        wake_measure("R8 pdown", DEEP_LAT, 5'b11110);
        lpt_ie = 1'b0;
    endtask

    task automatic t_psave;
        lpt_async = 1'b1;
        do_strobe(3'b011, 1'b1);
        chk_en("R4", 5'b00001);
        @(negedge clk);
        lpt_async = 1'b0;
        @(negedge clk);
        chk_en("R4", 5'b00110);
        lpt_ie = 1'b1; gie = 1'b0; lpt_evt = 1'b1;
        @(negedge clk);
        lpt_evt = 1'b0;
        chk("R6", "no wake with gie clear", {31'd0, sleeping}, 32'd1);
        gie = 1'b1; lpt_evt = 1'b1;
        wake_measure("R6 psave timer", DEEP_LAT, 5'b11110);
        lpt_ie = 1'b0;
    endtask

    task automatic t_standby;
        xtal_cfg = 1'b1;
        do_strobe(3'b110, 1'b1);
        chk_en("R5", 5'b00010);
        @(negedge clk);
        ext_req = 2'b10; ext_level = 2'b10;
        wake_measure("R8 standby", STBY_LAT, 5'b11110);
    endtask

    task automatic t_prr;
        @(negedge clk);
        pr_wr = 1'b1; pr_wdata = 8'b0000_0100;
        @(negedge clk);
        pr_wr = 1'b0;
        chk("R9", "bit2 gated", {24'd0, pr_clk_en}, 32'hFB);
        acc_idx = 3'd2; acc_rd = 1'b1; acc_wr = 1'b1;
        #0.1;
        chk("R10", "gated read", {24'd0, acc_rdata}, 32'd0);
        chk("R10", "gated write", {24'd0, per_wr}, 32'd0);
        acc_idx = 3'd5;
        #0.1;
        chk("R10", "open read", {24'd0, acc_rdata}, 32'h35);
        chk("R10", "open write", {24'd0, per_wr}, 32'h20);
        acc_rd = 1'b0; acc_wr = 1'b0;
        @(negedge clk);
        pr_wr = 1'b1; pr_wdata = '0;
        @(negedge clk);
        pr_wr = 1'b0;
        chk("R9", "bit2 restored", {24'd0, pr_clk_en}, 32'hFF);
        acc_idx = 3'd2; acc_rd = 1'b1;
        #0.1;
        chk("R10", "restored read", {24'd0, acc_rdata}, 32'h32);
        acc_rd = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NPER; i++) per_rdata[i*DW +: DW] = 8'h30 + 8'(i);
        t_reset();
        t_gating();
        t_idle();
        t_pdown();
        t_psave();
        t_standby();
        t_prr();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule